// File: doc/BRIEF.md
# Subclock Interval Watch Timer

This block is a watch-timer peripheral. A 15-bit counter advances once for every subclock tick, where a tick is a one-cycle enable in the system clock domain. A 3-bit select chooses one counter bit as the interval tap. The period runs from 2^8 to 2^15 ticks, which is 31.25 ms to 4.0 s when the subclock runs at 8.192 kHz. When the selected tap carries out, an overflow flag is set. The flag can drive an interrupt request line.

Software uses one 8-bit control/status register on a simple synchronous bus. One strobe selects the register and a second signal chooses write or read. Read data appears one cycle after the read strobe.

The register holds the following fields. Writing zero to the counter-clear bit zeroes the counter. Writing zero to the flag bit clears the flag. A read-only bit shows whether the oscillator has finished stabilising. A watchdog clock-source select drives an output that chooses between this timer and the time base timer. That output is held at the watch-timer setting while the chip runs in subclock mode.

Top module: `subclk_watch_timer`

## Requirements
- R1: After reset the register reads {bit7=1, bit6=osc_stable, bit5=0, bit4=0, bit3=1, bits2:0=000}, which is 0x88 with osc_stable low. The watchdog source output is 1 when not in subclock mode.
- R2: With interval select sel in bits 2:0, the overflow flag (bit 4) stays 0 through 2^(8+sel)-1 ticks after a counter clear. It is 1 after the 2^(8+sel)-th tick.
- R3: Writing 0 to bit 3 zeroes the counter. Writing 1 to bit 3 leaves the count unchanged. Bit 3 always reads 1.
- R4: When a counter clear and a tick fall in the same cycle, the counter ends at zero and no overflow is reported for that cycle.
- R5: Writing 0 to bit 4 clears the flag. Writing 1 to bit 4 leaves the flag unchanged.
- R6: When a write of 0 to bit 4 coincides with a new overflow, the flag ends at 1.
- R7: irq_req is 1 exactly when the flag is 1 and the interrupt enable (bit 5) is 1.
- R8: Bit 6 reads the osc_stable input. Writes to bit 6 change nothing.
- R9: Bit 7 reads back as written. wdog_src_tb equals bit 7 while sub_mode is 0 and is forced to 0 while sub_mode is 1.
- R10: Read data appears the cycle after a read strobe and holds until the next read strobe.
- R11: The counter advances only in cycles where sub_tick is 1. Cycles without a tick leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle subclock tick enable |
| osc_stable | input | 1 | Oscillator stabilisation finished |
| sub_mode | input | 1 | 1 while the chip runs from the subclock |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after a read strobe |
| irq_req | output | 1 | Interval interrupt request |
| wdog_src_tb | output | 1 | Watchdog clock source: 1 = time base timer, 0 = watch timer |

## Verification
Two collisions are provoked on purpose. In the first, a software write that clears the flag lands exactly on the tick that completes an interval. The bench counts ticks so that the write and the 512th tick share one clock edge, then reads the flag and expects 1. In the second, a counter-clear write lands on a tick. The bench expects no flag at that point, and then expects the flag only after a further full 256 ticks. A design where the tick wins would overflow early and fail that check.

// File: rtl/wt_pkg.sv
`timescale 1ns/1ps
package wt_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned CNT_W   = 15;
  localparam int unsigned TAP_LOG = 8;
  // control/status field positions
  localparam int unsigned F_SEL  = 0;
  localparam int unsigned F_CLR  = 3;
  localparam int unsigned F_FLAG = 4;
  localparam int unsigned F_IE   = 5;
  localparam int unsigned F_OSC  = 6;
  localparam int unsigned F_WDS  = 7;

  typedef struct packed {
    logic             wds;
    logic             ie;
    logic             flag;
    logic [SEL_W-1:0] sel;
  } wt_fields_t;
endpackage

// File: rtl/wt_rst_sync.sv
`timescale 1ns/1ps
module wt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wt_counter.sv
`timescale 1ns/1ps
module wt_counter #(
  parameter int unsigned CNT_W    = 15,
  parameter int unsigned TAP_LOG  = 8,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             ovf
);
  localparam int unsigned NTAP = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, low_mask;
  logic             cnt_en;
  logic [NTAP-1:0]  tap_fall;

  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign cnt_en   = clr | tick;
  assign low_mask = (CNT_W'(1) << (TAP_LOG + 32'(sel))) - CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // carry out of the low (TAP_LOG+g) bits shows as a falling tap bit
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign tap_fall[g] = cnt_q[TAP_LOG-1+g] & ~cnt_inc[TAP_LOG-1+g];
  end

  assign ovf = tick & ~clr & tap_fall[sel];

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R2
  ovf_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ((cnt_q & $past(low_mask)) == '0));
endmodule

// File: rtl/wt_ctrl_reg.sv
`timescale 1ns/1ps
module wt_ctrl_reg
  import wt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             ovf,
  output wt_fields_t       fields,
  output logic             cnt_clr
);
  wt_fields_t fld_q, fld_d;
  logic       flag_wclr;

  assign flag_wclr = wr_en & ~wdata[F_FLAG];
  assign cnt_clr   = wr_en & ~wdata[F_CLR];

  always_comb begin
    fld_d = fld_q;
    if (wr_en) begin
      fld_d.sel = wdata[F_SEL +: SEL_W];
      fld_d.ie  = wdata[F_IE];
      fld_d.wds = wdata[F_WDS];
    end
    if (ovf)            fld_d.flag = 1'b1;
    else if (flag_wclr) fld_d.flag = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q.sel  <= '0;
      fld_q.ie   <= 1'b0;
      fld_q.flag <= 1'b0;
      fld_q.wds  <= 1'b1;
    end else begin
      fld_q <= fld_d;
    end
  end

  assign fields = fld_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> fld_q.flag);
  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wclr && !ovf) |=> !fld_q.flag);
  // R5
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !flag_wclr) |=> $stable(fld_q.flag));
endmodule

// File: rtl/wt_rd_port.sv
`timescale 1ns/1ps
module wt_rd_port
  import wt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  wt_fields_t       fields,
  input  logic             osc_stable,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d                 = '0;
    rdata_d[F_SEL +: SEL_W] = fields.sel;
    rdata_d[F_CLR]          = 1'b1;
    rdata_d[F_FLAG]         = fields.flag;
    rdata_d[F_IE]           = fields.ie;
    rdata_d[F_OSC]          = osc_stable;
    rdata_d[F_WDS]          = fields.wds;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R3
  clr_bit_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rdata_q[F_CLR]);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/subclk_watch_timer.sv
`timescale 1ns/1ps
module subclk_watch_timer
  import wt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_tick,
  input  logic             osc_stable,
  input  logic             sub_mode,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq_req,
  output logic             wdog_src_tb
);
  logic       rst_s_n;
  logic       wr_en, rd_en, cnt_clr, ovf;
  wt_fields_t fields;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  wt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n)
  );

  wt_counter #(.CNT_W(CNT_W), .TAP_LOG(TAP_LOG), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .tick(sub_tick), .clr(cnt_clr),
    .sel(fields.sel), .ovf(ovf)
  );

  wt_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wdata(bus_wdata),
    .ovf(ovf), .fields(fields), .cnt_clr(cnt_clr)
  );

  wt_rd_port u_rd (
    .clk(clk), .rst_n(rst_s_n), .rd_en(rd_en), .fields(fields),
    .osc_stable(osc_stable), .rdata(bus_rdata)
  );

  assign irq_req     = fields.flag & fields.ie;
  assign wdog_src_tb = fields.wds & ~sub_mode;

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ovf && fields.ie && !wr_en) |=> irq_req);
endmodule

// File: tb/subclk_watch_timer_test.sv
`timescale 1ns/1ps
module subclk_watch_timer_test;
  logic       clk = 1'b0;
  logic       rst_n, sub_tick, osc_stable, sub_mode, bus_sel, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq_req, wdog_src_tb;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rv;

  logic [2:0] sh_sel;
  logic       sh_ie, sh_wds;

  always #2.5 clk = ~clk;

  subclk_watch_timer uut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .osc_stable(osc_stable),
    .sub_mode(sub_mode), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .wdog_src_tb(wdog_src_tb)
  );

  // monitor: note read strobes, compare one cycle later
  always @(posedge clk) rv <= rst_n & bus_sel & ~bus_wr;

  always @(negedge clk) begin
    if (rv === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL read with empty scoreboard act=%02h", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s act=%02h exp=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  function automatic logic [7:0] exp_reg(input logic flag);
    return {sh_wds, osc_stable, sh_ie, flag, 1'b1, sh_sel};
  endfunction

  function automatic logic [7:0] wbyte(input logic clr_cnt, input logic clr_flag);
    return {sh_wds, 1'b0, sh_ie, ~clr_flag, ~clr_cnt, sh_sel};
  endfunction

  task automatic wr(input logic [7:0] d, input logic tk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d; sub_tick = tk;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; sub_tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      sub_tick = 1'b1;
      @(negedge clk);
    end
    sub_tick = 1'b0;
  endtask

  task automatic chk(input string t, input logic act, input logic e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", t, act, e);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sub_tick = 1'b0; osc_stable = 1'b0; sub_mode = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; rv = 1'b0;
    sh_sel = 3'd0; sh_ie = 1'b0; sh_wds = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h88, "R1 reset value");
    chk("R1 wdog source after reset", wdog_src_tb, 1'b1);
    chk("R7 irq idle after reset", irq_req, 1'b0);

    // R8 status bit follows input, writes ignored
    osc_stable = 1'b1;
    rd(8'hC8, "R8 osc bit set");
    osc_stable = 1'b0;
    wr(8'hD8, 1'b0);
    rd(8'h88, "R8 write to bit6 ignored");
    osc_stable = 1'b1;

    // R2 sel=0 interval
    wr(wbyte(1'b1, 1'b1), 1'b0);
    tick_n(255);
    rd(exp_reg(1'b0), "R2 sel0 before 256th tick");
    tick_n(1);
    rd(exp_reg(1'b1), "R2 sel0 at 256th tick");
    chk("R7 irq held off with enable 0", irq_req, 1'b0);

    // R5 flag write semantics, R7 irq gating
    wr(wbyte(1'b0, 1'b0), 1'b0);
    rd(exp_reg(1'b1), "R5 writing 1 keeps flag");
    sh_ie = 1'b1;
    wr(wbyte(1'b0, 1'b0), 1'b0);
    chk("R7 irq follows flag with enable", irq_req, 1'b1);
    wr(wbyte(1'b0, 1'b1), 1'b0);
    chk("R7 irq drops with flag", irq_req, 1'b0);
    rd(exp_reg(1'b0), "R5 writing 0 clears flag");

    // R11 ticks separated by idle cycles
    wr(wbyte(1'b1, 1'b0), 1'b0);
    for (int i = 0; i < 255; i++) begin
      sub_tick = 1'b1; @(negedge clk);
      sub_tick = 1'b0; @(negedge clk);
    end
    rd(exp_reg(1'b0), "R11 idle cycles do not count");
    tick_n(1);
    chk("R11 overflow at 256th sparse tick", irq_req, 1'b1);
    wr(wbyte(1'b0, 1'b1), 1'b0);

    // R3 writing 1 to clear bit leaves count
    wr(wbyte(1'b1, 1'b1), 1'b0);
    tick_n(255);
    wr(wbyte(1'b0, 1'b0), 1'b0);
    tick_n(1);
    chk("R3 write 1 to clear bit no effect", irq_req, 1'b1);
    wr(wbyte(1'b0, 1'b1), 1'b0);

    // R4 clear beats tick
    wr(wbyte(1'b1, 1'b1), 1'b0);
    tick_n(255);
    wr(wbyte(1'b1, 1'b0), 1'b1);
    chk("R4 no overflow on clear+tick", irq_req, 1'b0);
    tick_n(255);
    chk("R4 count restarted from zero", irq_req, 1'b0);
    tick_n(1);
    chk("R4 overflow one period after clear", irq_req, 1'b1);

    // R6 set beats software clear (count now 256, flag 1)
    tick_n(255);
    wr(wbyte(1'b0, 1'b1), 1'b1);
    rd(exp_reg(1'b1), "R6 overflow wins over flag clear");
    wr(wbyte(1'b0, 1'b1), 1'b0);
    rd(exp_reg(1'b0), "R6 flag clear afterwards");

    // R2 sel=2
    sh_sel = 3'd2;
    wr(wbyte(1'b1, 1'b1), 1'b0);
    tick_n(1023);
    chk("R2 sel2 before 1024th tick", irq_req, 1'b0);
    tick_n(1);
    chk("R2 sel2 at 1024th tick", irq_req, 1'b1);

    // R2 sel=7
    sh_sel = 3'd7;
    wr(wbyte(1'b1, 1'b1), 1'b0);
    tick_n(32767);
    chk("R2 sel7 before 32768th tick", irq_req, 1'b0);
    tick_n(1);
    chk("R2 sel7 at 32768th tick", irq_req, 1'b1);
    rd(exp_reg(1'b1), "R2 sel7 readback");
    wr(wbyte(1'b0, 1'b1), 1'b0);

    // R9 watchdog source select
    sub_mode = 1'b1;
    #1;
    chk("R9 forced to watch timer in subclock mode", wdog_src_tb, 1'b0);
    rd(exp_reg(1'b0), "R9 bit7 still reads 1 in subclock mode");
    sub_mode = 1'b0;
    #1;
    chk("R9 follows bit7 outside subclock mode", wdog_src_tb, 1'b1);
    sh_wds = 1'b0;
    wr(wbyte(1'b0, 1'b0), 1'b0);
    chk("R9 bit7 written 0", wdog_src_tb, 1'b0);
    rd(exp_reg(1'b0), "R9 bit7 readback 0");

    // R10 read data holds between reads
    begin
      logic [7:0] held;
      held = exp_reg(1'b0);
      sh_ie = 1'b0;
      wr(wbyte(1'b0, 1'b0), 1'b0);
      repeat (3) @(negedge clk);
      checks++;
      if (bus_rdata !== held) begin
        errors++;
        $display("FAIL R10 read data changed without read act=%02h exp=%02h",
                 bus_rdata, held);
      end
      rd(exp_reg(1'b0), "R10 new read shows new enable");
    end

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d reads act=%0d exp=0", exp_q.size(), exp_q.size());
    end
    finish_run();
  end
endmodule